// File: doc/BRIEF.md
# I2C Target Port with Host-Controlled Clock Hold

This block is the target side of a two-wire serial bus. It uses a 7-bit address and holds one byte of data. The block synchronizes the clock and data lines to the system clock and recognizes start and stop conditions. It shifts in the first byte after every start and compares the upper seven bits with a programmable own address. Address zero can also be accepted when the general-call enable is set. On a match the block pulls the data line low for the ninth clock. Received address and data bytes land in a single buffer register. A host on the system side reads that buffer through a read strobe. When the bus master reads from the block, the host writes the byte to be sent into the same buffer.

The host sees a set of status bits:

- buffer full
- sticky overflow
- sticky write collision
- whether the last byte loaded was data or an address
- the direction bit of the last match
- whether the last match was a general call
- whether a start or a stop was seen last

The block can hold the clock line low between bytes. An internal release bit is cleared by the block when it begins to hold, and the host sets it again with a one-cycle release strobe. When the block transmits, it always holds after the address and after every byte the master acknowledges. When it receives, it holds only while stretch-enable is set.

The controller is a state machine with eight states:

- IDLE waits for a start.
- ADDR shifts in the address byte. On a match with room in the buffer it moves to ADDR_ACK. Otherwise it moves to SKIP.
- ADDR_ACK drives the acknowledge. On the next clock fall it goes to TX for a read or RX for a write.
- RX shifts in a data byte. It moves to RX_ACK if the byte is accepted, or to SKIP if it is refused.
- RX_ACK drives the acknowledge, then returns to RX on the clock fall.
- TX drives eight bits, then moves to TX_ACK.
- TX_ACK samples the master's acknowledge. On an acknowledge it returns to TX. On a not-acknowledge it goes to SKIP.
- SKIP ignores the bus until the next condition.

From any state, a start leads to ADDR and a stop leads to IDLE.

Top module: `i2c_tgt_stretch`

## Requirements
- R1: A start condition (data falls while clock is high) sets `st_start` and clears `st_stop`. A stop condition (data rises while clock is high) sets `st_stop` and clears `st_start`.
- R2: The first byte after a start is acknowledged (data held low during the ninth clock) only if bits 7:1 equal `own_addr`. A refused address leaves data released for the rest of that transfer, and no byte of it reaches the buffer.
- R3: With `gcall_en` set, address 0 is also acknowledged and `st_gcall` reads 1. With `gcall_en` clear, address 0 is refused. `st_gcall` reads 0 after a match on the own address.
- R4: An accepted address or data byte is loaded into the buffer. It sets `st_full` and appears on `buf_rdata`. `st_data` reads 0 after an address and 1 after a data byte. A `buf_rd` strobe clears `st_full`.
- R5: A byte that completes while `st_full` is set sets `st_ovf`, is not acknowledged, and leaves the buffer unchanged. While `st_ovf` is set every byte, address included, is refused. `st_ovf` clears only on `ovf_clr`.
- R6: `st_rw` holds bit 0 of the most recent accepted address byte (1 = master reads).
- R7: After an acknowledged byte of a write transfer, the clock line is held low (`scl_oe`=1) only when `stretch_en` is 1. The hold stays until a `rel_set` strobe.
- R8: In a read transfer the block always holds the clock after the address acknowledge and after each byte the master acknowledges. It sends the buffer most significant bit first, clears `st_full` once the eighth bit is out, and releases both lines after a not-acknowledge from the master.
- R9: A `buf_wr` while a byte is being shifted out (read transfer, clock not held) sets sticky `st_col` and does not change the buffer. `col_clr` clears `st_col`.
- R10: After reset every status bit is 0 and neither line is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sensed level of the bus clock line |
| sda_in | input | 1 | Sensed level of the bus data line |
| scl_oe | output | 1 | 1 pulls the clock line low (hold) |
| sda_oe | output | 1 | 1 pulls the data line low |
| own_addr | input | 7 | Programmable target address |
| gcall_en | input | 1 | Accept address 0 as well |
| stretch_en | input | 1 | Hold clock after received bytes too |
| rel_set | input | 1 | Strobe: set the release bit and free the clock |
| buf_wr | input | 1 | Strobe: write `buf_wdata` into the buffer |
| buf_wdata | input | 8 | Byte to transmit |
| buf_rd | input | 1 | Strobe: host has read the buffer |
| buf_rdata | output | 8 | Buffer contents |
| ovf_clr | input | 1 | Strobe: clear overflow flag |
| col_clr | input | 1 | Strobe: clear collision flag |
| st_full | output | 1 | Buffer holds an unread or unsent byte |
| st_ovf | output | 1 | Sticky overflow |
| st_col | output | 1 | Sticky write collision |
| st_data | output | 1 | Last loaded byte was data (1) or address (0) |
| st_rw | output | 1 | Direction bit of the last match |
| st_gcall | output | 1 | Last match was the general-call address |
| st_start | output | 1 | Start seen last |
| st_stop | output | 1 | Stop seen last |

## Verification
A bus edge reaches the state register three system clocks later: two synchronizer flops, then the state flop. The acknowledge drive, transmit bits and clock hold therefore appear three cycles after the SCL edge that causes them. The bench holds every SCL phase for eight cycles and samples bus levels at the last falling system edge of each phase, well after that delay. Host strobes are applied for one cycle starting at a falling system edge, and the status they change is compared at the next falling edge, one register stage later. Hold checks are taken after the ninth low phase has run out, and again twenty cycles later.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    localparam int ADDR_W = 7;
    localparam int DATA_W = 8;
    localparam int CNT_W  = $clog2(DATA_W + 1);
    localparam int IDX_W  = $clog2(DATA_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_SKIP
    } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sr;
    logic [STAGES-1:0] sda_sr;
    logic              scl_q;
    logic              sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sr <= '1;
            sda_sr <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sr <= {scl_sr[STAGES-2:0], scl_in};
            sda_sr <= {sda_sr[STAGES-2:0], sda_in};
            scl_q  <= scl_sr[STAGES-1];
            sda_q  <= sda_sr[STAGES-1];
        end
    end

    always_comb begin
        scl_s     = scl_sr[STAGES-1];
        sda_s     = sda_sr[STAGES-1];
        scl_rise  = scl_s && !scl_q;
        scl_fall  = !scl_s && scl_q;
        start_det = scl_s && scl_q && sda_q && !sda_s;
        stop_det  = scl_s && scl_q && !sda_q && sda_s;
    end
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gcall_en,
    input  logic              stretch_en,
    input  logic              rel_set,
    input  logic              buf_full,
    input  logic              ovf_flag,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              sda_oe,
    output logic              ckp,
    output logic              ld_en,
    output logic              ld_is_data,
    output logic [DATA_W-1:0] ld_byte,
    output logic              match_ev,
    output logic              match_rw,
    output logic              match_gc,
    output logic              ovf_ev,
    output logic              tx_done,
    output logic              tx_busy
);
    tgt_state_e        state, nxt;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] sh;
    logic              rw_q;
    logic              mack_q;
    logic              hold_req;
    logic              hit;
    logic              accept;
    logic              byte_end;
    logic [IDX_W-1:0]  tx_idx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state and event strobes
    always_comb begin
        nxt        = state;
        ld_en      = 1'b0;
        ld_is_data = 1'b0;
        match_ev   = 1'b0;
        ovf_ev     = 1'b0;
        tx_done    = 1'b0;
        hold_req   = 1'b0;
        hit        = (sh[DATA_W-1:1] == own_addr) ||
                     (gcall_en && (sh[DATA_W-1:1] == '0));
        accept     = !buf_full && !ovf_flag;
        byte_end   = scl_fall && (cnt == CNT_W'(DATA_W));
        if (start_det) begin
            nxt = ST_ADDR;
        end else if (stop_det) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: nxt = ST_IDLE;
                ST_ADDR: begin
                    if (byte_end) begin
                        if (hit && accept) begin
                            ld_en    = 1'b1;
                            match_ev = 1'b1;
                            nxt      = ST_ADDR_ACK;
                        end else begin
                            ovf_ev = hit && buf_full;
                            nxt    = ST_SKIP;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        nxt      = rw_q ? ST_TX : ST_RX;
                        hold_req = rw_q || stretch_en;
                    end
                end
                ST_RX: begin
                    if (byte_end) begin
                        if (accept) begin
                            ld_en      = 1'b1;
                            ld_is_data = 1'b1;
                            nxt        = ST_RX_ACK;
                        end else begin
                            ovf_ev = buf_full;
                            nxt    = ST_SKIP;
                        end
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        nxt      = ST_RX;
                        hold_req = stretch_en;
                    end
                end
                ST_TX: begin
                    if (scl_fall && (cnt == CNT_W'(DATA_W - 1))) begin
                        nxt     = ST_TX_ACK;
                        tx_done = 1'b1;
                    end
                end
                ST_TX_ACK: begin
                    if (scl_fall) begin
                        if (mack_q) begin
                            nxt      = ST_TX;
                            hold_req = 1'b1;
                        end else begin
                            nxt = ST_SKIP;
                        end
                    end
                end
                ST_SKIP: nxt = ST_SKIP;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // bit counter, shifter, captured bits, release bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            sh     <= '0;
            rw_q   <= 1'b0;
            mack_q <= 1'b0;
            ckp    <= 1'b1;
        end else begin
            if (start_det || stop_det || (nxt != state)) begin
                cnt <= '0;
            end else if (((state == ST_ADDR) || (state == ST_RX)) && scl_rise) begin
                cnt <= cnt + 1'b1;
                sh  <= {sh[DATA_W-2:0], sda_s};
            end else if ((state == ST_TX) && scl_fall) begin
                cnt <= cnt + 1'b1;
            end
            if (match_ev) rw_q <= sh[0];
            if ((state == ST_TX_ACK) && scl_rise) mack_q <= !sda_s;
            if (hold_req)     ckp <= 1'b0;
            else if (rel_set) ckp <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        tx_idx   = IDX_W'(DATA_W - 1) - cnt[IDX_W-1:0];
        sda_oe   = (state == ST_ADDR_ACK) || (state == ST_RX_ACK) ||
                   ((state == ST_TX) && !tx_byte[tx_idx]);
        tx_busy  = (state == ST_TX) && ckp;
        ld_byte  = sh;
        match_rw = sh[0];
        match_gc = (sh[DATA_W-1:1] == '0);
    end

    // R2: the data line only starts being pulled while the clock is low
    a_r2_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);
    // R7: a hold only begins while the clock is already low
    a_r7_hold_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ckp) |-> !scl_s);
    // R5: a byte is never loaded over an unread one
    a_r5_no_load_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |-> (!buf_full && !ovf_flag));
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic              ld_is_data,
    input  logic [DATA_W-1:0] ld_byte,
    input  logic              match_ev,
    input  logic              match_rw,
    input  logic              match_gc,
    input  logic              ovf_ev,
    input  logic              tx_done,
    input  logic              tx_busy,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_wdata,
    input  logic              buf_rd,
    input  logic              ovf_clr,
    input  logic              col_clr,
    input  logic              start_det,
    input  logic              stop_det,
    output logic [DATA_W-1:0] dbuf,
    output logic              full,
    output logic              ovf,
    output logic              col,
    output logic              is_data,
    output logic              rw,
    output logic              gcall,
    output logic              seen_start,
    output logic              seen_stop
);
    logic wr_ok;

    always_comb wr_ok = buf_wr && !tx_busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dbuf       <= '0;
            full       <= 1'b0;
            ovf        <= 1'b0;
            col        <= 1'b0;
            is_data    <= 1'b0;
            rw         <= 1'b0;
            gcall      <= 1'b0;
            seen_start <= 1'b0;
            seen_stop  <= 1'b0;
        end else begin
            if (ld_en)      dbuf <= ld_byte;
            else if (wr_ok) dbuf <= buf_wdata;

            if (ld_en || wr_ok)        full <= 1'b1;
            else if (buf_rd || tx_done) full <= 1'b0;

            if (ovf_ev)       ovf <= 1'b1;
            else if (ovf_clr) ovf <= 1'b0;

            if (buf_wr && tx_busy) col <= 1'b1;
            else if (col_clr)      col <= 1'b0;

            if (ld_en) is_data <= ld_is_data;

            if (match_ev) begin
                rw    <= match_rw;
                gcall <= match_gc;
            end

            if (start_det) begin
                seen_start <= 1'b1;
                seen_stop  <= 1'b0;
            end else if (stop_det) begin
                seen_stop  <= 1'b1;
                seen_start <= 1'b0;
            end
        end
    end

    // R5: overflow holds until software clears it
    a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);
    // R9: a collision can only come from a write during shifting
    a_r9_col_from_tx: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(col) |-> $past(tx_busy));
    // R1: start and stop flags never both set
    a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(seen_start && seen_stop));
    // R4: the host read empties the buffer unless a new byte arrives
    a_r4_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd && !ld_en && !buf_wr) |=> !full);
endmodule

// File: rtl/i2c_tgt_stretch.sv
module i2c_tgt_stretch
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gcall_en,
    input  logic              stretch_en,
    input  logic              rel_set,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_wdata,
    input  logic              buf_rd,
    output logic [DATA_W-1:0] buf_rdata,
    input  logic              ovf_clr,
    input  logic              col_clr,
    output logic              st_full,
    output logic              st_ovf,
    output logic              st_col,
    output logic              st_data,
    output logic              st_rw,
    output logic              st_gcall,
    output logic              st_start,
    output logic              st_stop
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic ckp, ld_en, ld_is_data, match_ev, match_rw, match_gc;
    logic ovf_ev, tx_done, tx_busy;
    logic [DATA_W-1:0] ld_byte;
    logic [DATA_W-1:0] dbuf;

    i2c_tgt_sync #(.STAGES(2)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tgt_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s      (scl_s),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .own_addr   (own_addr),
        .gcall_en   (gcall_en),
        .stretch_en (stretch_en),
        .rel_set    (rel_set),
        .buf_full   (st_full),
        .ovf_flag   (st_ovf),
        .tx_byte    (dbuf),
        .sda_oe     (sda_oe),
        .ckp        (ckp),
        .ld_en      (ld_en),
        .ld_is_data (ld_is_data),
        .ld_byte    (ld_byte),
        .match_ev   (match_ev),
        .match_rw   (match_rw),
        .match_gc   (match_gc),
        .ovf_ev     (ovf_ev),
        .tx_done    (tx_done),
        .tx_busy    (tx_busy)
    );

    i2c_tgt_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_en      (ld_en),
        .ld_is_data (ld_is_data),
        .ld_byte    (ld_byte),
        .match_ev   (match_ev),
        .match_rw   (match_rw),
        .match_gc   (match_gc),
        .ovf_ev     (ovf_ev),
        .tx_done    (tx_done),
        .tx_busy    (tx_busy),
        .buf_wr     (buf_wr),
        .buf_wdata  (buf_wdata),
        .buf_rd     (buf_rd),
        .ovf_clr    (ovf_clr),
        .col_clr    (col_clr),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .dbuf       (dbuf),
        .full       (st_full),
        .ovf        (st_ovf),
        .col        (st_col),
        .is_data    (st_data),
        .rw         (st_rw),
        .gcall      (st_gcall),
        .seen_start (st_start),
        .seen_stop  (st_stop)
    );

    always_comb begin
        scl_oe    = !ckp;
        buf_rdata = dbuf;
    end
endmodule

// File: tb/tb_i2c_tgt_stretch.sv
`timescale 1ns/1ps
module tb_i2c_tgt_stretch;
    localparam int HALF = 8;
    localparam logic [6:0] OWN = 7'h2A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_bus, sda_bus;
    logic scl_oe, sda_oe;
    logic [6:0] own_addr = OWN;
    logic gcall_en = 1'b0, stretch_en = 1'b0, rel_set = 1'b0;
    logic buf_wr = 1'b0, buf_rd = 1'b0, ovf_clr = 1'b0, col_clr = 1'b0;
    logic [7:0] buf_wdata = '0;
    logic [7:0] buf_rdata;
    logic st_full, st_ovf, st_col, st_data, st_rw, st_gcall, st_start, st_stop;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    assign scl_bus = scl_m & ~scl_oe;
    assign sda_bus = sda_m & ~sda_oe;

    i2c_tgt_stretch dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_bus), .sda_in(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own_addr),
        .gcall_en(gcall_en), .stretch_en(stretch_en), .rel_set(rel_set),
        .buf_wr(buf_wr), .buf_wdata(buf_wdata), .buf_rd(buf_rd),
        .buf_rdata(buf_rdata), .ovf_clr(ovf_clr), .col_clr(col_clr),
        .st_full(st_full), .st_ovf(st_ovf), .st_col(st_col),
        .st_data(st_data), .st_rw(st_rw), .st_gcall(st_gcall),
        .st_start(st_start), .st_stop(st_stop)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
        @(negedge clk);
    endtask

    // one clock pulse; returns the data level sampled at the end of the high phase
    task automatic clk_pulse(output logic smp);
        scl_m = 1'b1;
        @(negedge clk);
        while (!scl_bus) @(negedge clk);
        wait_cyc(HALF);
        smp = sda_bus;
        scl_m = 1'b0;
        wait_cyc(HALF);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1;
        wait_cyc(HALF);
        sda_m = 1'b0;
        wait_cyc(HALF);
        scl_m = 1'b0;
        wait_cyc(HALF);
    endtask

    task automatic bus_stop();
        logic d;
        sda_m = 1'b0;
        wait_cyc(2);
        scl_m = 1'b1;
        @(negedge clk);
        while (!scl_bus) @(negedge clk);
        wait_cyc(HALF);
        sda_m = 1'b1;
        wait_cyc(HALF);
        d = sda_bus;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i];
            clk_pulse(s);
        end
        sda_m = 1'b1;
        clk_pulse(s);
        acked = !s;
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        logic s;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            clk_pulse(s);
            b[i] = s;
        end
        sda_m = nack;
        clk_pulse(s);
        sda_m = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic ak;
        logic [7:0] rb;
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);
        // R10: reset state
        chk("R10 flags", {st_full, st_ovf, st_col, st_data, st_rw, st_gcall, st_start, st_stop}, 0);
        chk("R10 lines", {scl_oe, sda_oe}, 0);

        // R2/R3/R4: sweep every address with and without general call
        for (int g = 0; g < 2; g++) begin
            gcall_en = g[0];
            for (int a = 0; a < 128; a++) begin
                logic exp_ack;
                exp_ack = (a == int'(OWN)) || (g == 1 && a == 0);
                bus_start();
                chk("R1 start flag", {st_start, st_stop}, 2'b10);
                send_byte({a[6:0], 1'b0}, ak);
                chk($sformatf("R2 R3 ack g=%0d a=%0h", g, a), ak, exp_ack);
                if (exp_ack) begin
                    chk("R4 full after address", st_full, 1);
                    chk("R4 address byte", buf_rdata, {a[6:0], 1'b0});
                    chk("R4 address flag", st_data, 0);
                    chk("R3 gcall flag", st_gcall, (a == 0) ? 1 : 0);
                    pulse(buf_rd);
                    chk("R4 read clears full", st_full, 0);
                end else begin
                    send_byte(8'h55, ak);
                    chk("R2 ignored byte not acked", ak, 0);
                    chk("R2 ignored byte not loaded", st_full, 0);
                end
                bus_stop();
                chk("R1 stop flag", {st_start, st_stop}, 2'b01);
            end
        end
        gcall_en = 1'b0;

        // R4/R5/R6/R7: write transfer without stretch, then overflow
        bus_start();
        send_byte({OWN, 1'b0}, ak);
        chk("R2 own write acked", ak, 1);
        chk("R6 rw after write", st_rw, 0);
        pulse(buf_rd);
        send_byte(8'hA5, ak);
        chk("R4 data acked", ak, 1);
        chk("R4 data flag", st_data, 1);
        chk("R4 data byte", buf_rdata, 8'hA5);
        chk("R7 no hold when stretch off", scl_oe, 0);
        send_byte(8'h3C, ak);
        chk("R5 full byte refused", ak, 0);
        chk("R5 overflow set", st_ovf, 1);
        chk("R5 buffer kept", buf_rdata, 8'hA5);
        bus_stop();
        pulse(buf_rd);
        bus_start();
        send_byte({OWN, 1'b0}, ak);
        chk("R5 refused while overflow", ak, 0);
        chk("R5 nothing loaded", st_full, 0);
        bus_stop();
        chk("R5 overflow sticky", st_ovf, 1);
        pulse(ovf_clr);
        chk("R5 overflow cleared", st_ovf, 0);

        // R7: write transfer with stretch enabled
        stretch_en = 1'b1;
        bus_start();
        send_byte({OWN, 1'b0}, ak);
        chk("R7 address acked", ak, 1);
        chk("R7 hold after address", scl_oe, 1);
        wait_cyc(20);
        chk("R7 hold persists", scl_oe, 1);
        pulse(buf_rd);
        pulse(rel_set);
        chk("R7 release", scl_oe, 0);
        send_byte(8'h11, ak);
        chk("R7 data acked", ak, 1);
        chk("R7 hold after data", scl_oe, 1);
        chk("R7 data byte", buf_rdata, 8'h11);
        pulse(buf_rd);
        pulse(rel_set);
        bus_stop();
        stretch_en = 1'b0;

        // R6/R8/R9: read transfer
        bus_start();
        send_byte({OWN, 1'b1}, ak);
        chk("R8 read address acked", ak, 1);
        chk("R6 rw after read", st_rw, 1);
        chk("R8 hold after read address", scl_oe, 1);
        pulse(buf_rd);
        buf_wdata = 8'h96;
        pulse(buf_wr);
        chk("R8 full after write", st_full, 1);
        chk("R9 no collision while held", st_col, 0);
        pulse(rel_set);
        recv_byte(1'b0, rb);
        chk("R8 first byte", rb, 8'h96);
        chk("R8 full cleared after send", st_full, 0);
        chk("R8 hold after master ack", scl_oe, 1);
        buf_wdata = 8'h5B;
        pulse(buf_wr);
        pulse(rel_set);
        fork
            recv_byte(1'b1, rb);
            begin
                wait_cyc(30);
                buf_wdata = 8'hFF;
                pulse(buf_wr);
            end
        join
        chk("R9 collision set", st_col, 1);
        chk("R9 byte unchanged by collision", rb, 8'h5B);
        wait_cyc(4);
        chk("R8 lines released after nack", {scl_oe, sda_oe}, 0);
        bus_stop();
        chk("R1 stop after read", st_stop, 1);
        pulse(col_clr);
        chk("R9 collision cleared", st_col, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule